// File: doc/BRIEF.md
# Precise Exception Sequencer

This block rides alongside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) and makes faults precise. Every instruction entering fetch receives a small tag: a valid bit, a "flagged" bit and a cause code. A matching program counter value travels with the tag. Each stage can report one kind of fault for the instruction it holds. Fetch reports an address fault, decode an illegal opcode, execute an arithmetic overflow, and memory a bad data address. The first fault reported for an instruction is written into its tag. Later reports for that instruction are dropped.

Nothing is acted on while a fault is still in flight. The exception is taken only in the cycle the flagged instruction sits at the end of the memory stage. Because instructions reach that point strictly in program order, an older instruction's fault always wins, even if a younger instruction was flagged earlier in time. When an exception is taken, the block does four things in the same cycle. It raises a redirect to a fixed vector address, and it flushes the three younger instructions. It withholds the commit permission of the faulting instruction. It also captures that instruction's PC and cause into the EPC and cause registers.

An external interrupt is not a separate path. It is injected at fetch as a no-op that already carries the interrupt cause, so it is taken in order like any other fault. Fetch is expected to start at the vector address in the cycle after the redirect.

Top module: `exc_seq`

## Requirements
- R1: While rst_n is low, redirect, flush and commit_en are 0, and epc and cause read 0.
- R2: An instruction presented at fetch with if_valid=1 and no fault reaches the end of memory exactly 3 cycles later. In that cycle commit_en=1 and done_pc equals its fetch PC.
- R3: A flagged instruction causes redirect=1 only in the cycle it is at the end of memory (3 cycles after fetch). In that cycle commit_en=0, and no earlier cycle shows a redirect for it.
- R4: In the cycle after a redirect, epc equals the PC of the faulting instruction. epc and cause then hold their value until the next redirect, whatever other traffic passes.
- R5: cause encodes the fault kind as 1 = interrupt, 2 = fetch address, 3 = illegal opcode, 4 = overflow, 5 = data address. 0 means no exception has been taken since reset.
- R6: Once an instruction is flagged, fault inputs raised for it in later stages are ignored, and the first recorded cause is the one reported.
- R7: An older instruction flagged in a later stage is taken before a younger instruction that was flagged earlier in time. The younger instruction never produces a redirect.
- R8: The three instructions younger than a taken exception (those in fetch, decode and execute that cycle) are squashed. None of them produces commit_en or redirect.
- R9: irq_req=1 at fetch injects a faulting no-op with the current if_pc, even when if_valid=0. Its cause is interrupt, which takes precedence over a fetch address fault in the same cycle.
- R10: Whenever redirect=1, flush=1 and redirect_pc equals the VECTOR parameter (default 0x0000_0400). An instruction fetched from the vector in the next cycle flows normally.
- R11: A fault input raised while its stage holds no valid instruction has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | A real instruction is being fetched this cycle |
| if_pc | input | PC_W | PC of the instruction at fetch |
| irq_req | input | 1 | External interrupt; inject a faulting no-op at fetch |
| if_fault | input | 1 | Fetch-address fault for the instruction at fetch |
| id_fault | input | 1 | Illegal-opcode fault for the instruction in decode |
| ex_fault | input | 1 | Overflow for the instruction in execute |
| mem_fault | input | 1 | Data-address fault for the instruction in memory |
| redirect | output | 1 | Exception taken this cycle; load redirect_pc into fetch |
| redirect_pc | output | PC_W | Exception vector address |
| flush | output | 1 | Squash the younger instructions in fetch, decode and execute |
| commit_en | output | 1 | Instruction leaving memory may write state |
| done_pc | output | PC_W | PC of the instruction currently at the end of memory |
| epc | output | PC_W | PC of the last excepting instruction |
| cause | output | 3 | Cause code of the last exception |

## Verification
The assertions assume that each stage's fault input describes the instruction that stage holds in the same cycle. They also assume that fetch really does go to the vector after a redirect, so no stage register is refilled with squashed work. The bench respects both assumptions. It raises each stage's flag only in the cycle its target instruction sits in that stage, computed from the issue cycle. It also separates scenarios with idle cycles long enough for the pipeline to drain. Fault inputs raised on empty stages are driven only when the whole pipeline is idle, so they test the ignore rule without running into a flagged instruction.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    CS_NONE   = 3'd0,
    CS_IRQ    = 3'd1,
    CS_IFETCH = 3'd2,
    CS_ILLOP  = 3'd3,
    CS_OVF    = 3'd4,
    CS_DADDR  = 3'd5
  } cause_e;

  typedef struct packed {
    logic   valid;
    logic   flagged;
    cause_e cause;
  } tag_t;

  // First recorded fault wins; empty slots never pick up a fault.
  function automatic tag_t tag_merge(tag_t t, logic hit, cause_e code);
    tag_t r;
    r = t;
    if (t.valid && hit && !t.flagged) begin
      r.flagged = 1'b1;
      r.cause   = code;
    end
    return r;
  endfunction

endpackage

// File: rtl/exc_if_inject.sv
module exc_if_inject
  import exc_pkg::*;
(
  input  logic if_valid,
  input  logic irq_req,
  output tag_t tag
);

  // An interrupt becomes a no-op that is already flagged at fetch.
  always_comb begin
    tag.valid   = if_valid | irq_req;
    tag.flagged = irq_req;
    tag.cause   = irq_req ? CS_IRQ : CS_NONE;
  end

endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kill,
  input  tag_t            tag_d,
  input  logic [PC_W-1:0] pc_d,
  output tag_t            tag_q,
  output logic [PC_W-1:0] pc_q
);

  tag_t            tag_n;
  logic            pc_en;

  always_comb begin
    tag_n = kill ? tag_t'('0) : tag_d;
    pc_en = !kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else begin
      tag_q <= tag_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tag_t            mem_tag,
  input  logic [PC_W-1:0] mem_pc,
  output logic            take,
  output logic            commit,
  output logic [PC_W-1:0] epc_q,
  output cause_e          cause_q
);

  logic            cap_en;
  logic [PC_W-1:0] epc_n;
  cause_e          cause_n;

  always_comb begin
    take    = mem_tag.valid &  mem_tag.flagged;
    commit  = mem_tag.valid & ~mem_tag.flagged;
    cap_en  = take;
    epc_n   = mem_pc;
    cause_n = mem_tag.cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= CS_NONE;
    end else if (cap_en) begin
      epc_q   <= epc_n;
      cause_q <= cause_n;
    end
  end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int              PC_W   = 32,
  parameter logic [PC_W-1:0] VECTOR = 'h400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid,
  input  logic [PC_W-1:0] if_pc,
  input  logic            irq_req,
  input  logic            if_fault,
  input  logic            id_fault,
  input  logic            ex_fault,
  input  logic            mem_fault,
  output logic            redirect,
  output logic [PC_W-1:0] redirect_pc,
  output logic            flush,
  output logic            commit_en,
  output logic [PC_W-1:0] done_pc,
  output logic [PC_W-1:0] epc,
  output logic [2:0]      cause
);

  localparam int NREG  = 3;          // decode, execute, memory registers
  localparam int NSLOT = NREG + 1;   // plus the fetch slot

  localparam cause_e CODE [NSLOT] = '{CS_IFETCH, CS_ILLOP, CS_OVF, CS_DADDR};

  tag_t            tag_q [NSLOT];
  tag_t            tag_m [NSLOT];
  logic [PC_W-1:0] pc_q  [NSLOT];
  logic [NSLOT-1:0] hit;
  logic            take;
  logic            commit;
  cause_e          cause_q;

  assign hit = {mem_fault, ex_fault, id_fault, if_fault};

  exc_if_inject u_inj (
    .if_valid (if_valid),
    .irq_req  (irq_req),
    .tag      (tag_q[0])
  );
  assign pc_q[0] = if_pc;

  for (genvar k = 0; k < NSLOT; k++) begin : g_merge
    assign tag_m[k] = tag_merge(tag_q[k], hit[k], CODE[k]);
  end

  for (genvar k = 1; k < NSLOT; k++) begin : g_stage
    exc_stage_reg #(.PC_W(PC_W)) u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .kill  (take),
      .tag_d (tag_m[k-1]),
      .pc_d  (pc_q[k-1]),
      .tag_q (tag_q[k]),
      .pc_q  (pc_q[k])
    );
  end

  exc_commit #(.PC_W(PC_W)) u_cmt (
    .clk     (clk),
    .rst_n   (rst_n),
    .mem_tag (tag_m[NREG]),
    .mem_pc  (pc_q[NREG]),
    .take    (take),
    .commit  (commit),
    .epc_q   (epc),
    .cause_q (cause_q)
  );

  assign redirect    = take;
  assign flush       = take;
  assign redirect_pc = VECTOR;
  assign commit_en   = commit;
  assign done_pc     = pc_q[NREG];
  assign cause       = cause_q;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            redirect,
  input logic            commit_en,
  input logic [PC_W-1:0] done_pc,
  input logic [PC_W-1:0] epc,
  input logic [2:0]      cause
);

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redirect, commit_en})); // R3

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (epc == $past(done_pc))); // R4

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(redirect) |-> ($stable(epc) && $stable(cause))); // R4

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (cause >= 3'd1 && cause <= 3'd5)); // R5

  AST_SQUASH_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!redirect && !commit_en)); // R8

endmodule

bind exc_seq exc_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .redirect  (redirect),
  .commit_en (commit_en),
  .done_pc   (done_pc),
  .epc       (epc),
  .cause     (cause)
);

// File: tb/sim_exc_seq.sv
module sim_exc_seq;

  localparam int          PER = 10;
  localparam int          W   = 32;
  localparam logic [W-1:0] VEC = 32'h400;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         if_valid, irq_req, if_fault, id_fault, ex_fault, mem_fault;
  logic [W-1:0] if_pc;
  logic         redirect, flush, commit_en;
  logic [W-1:0] redirect_pc, done_pc, epc;
  logic [2:0]   cause;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;
  bit live   = 0;

  typedef struct {
    bit           is_exc;
    logic [W-1:0] pc;
    logic [2:0]   cz;
    int           due;
    string        req;
  } item_t;

  item_t sb[$];

  always #(PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  exc_seq #(.PC_W(W), .VECTOR(VEC)) u0 (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
    .irq_req(irq_req), .if_fault(if_fault), .id_fault(id_fault),
    .ex_fault(ex_fault), .mem_fault(mem_fault), .redirect(redirect),
    .redirect_pc(redirect_pc), .flush(flush), .commit_en(commit_en),
    .done_pc(done_pc), .epc(epc), .cause(cause)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic exp_commit(input logic [W-1:0] pc, input string req);
    item_t it;
    it.is_exc = 0; it.pc = pc; it.cz = 3'd0; it.due = cyc + 3; it.req = req;
    sb.push_back(it);
  endtask

  task automatic exp_exc(input logic [W-1:0] pc, input logic [2:0] cz, input string req);
    item_t it;
    it.is_exc = 1; it.pc = pc; it.cz = cz; it.due = cyc + 3; it.req = req;
    sb.push_back(it);
  endtask

  // One cycle of stimulus; inputs change just after a rising edge.
  task automatic go(input logic v, input logic [W-1:0] pc, input logic fi,
                    input logic irq, input logic fid, input logic fex, input logic fm);
    if_valid = v; if_pc = pc; if_fault = fi; irq_req = irq;
    id_fault = fid; ex_fault = fex; mem_fault = fm;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) go(0, '0, 0, 0, 0, 0, 0);
  endtask

  // Monitor: pops the scoreboard as results appear at the end of memory.
  bit           epc_due = 0;
  logic [W-1:0] epc_exp;
  logic [2:0]   cz_exp;
  string        cz_req;

  always @(negedge clk) begin
    if (live) begin
      if (epc_due) begin
        chk(epc == epc_exp, "R4", "epc after redirect", epc, epc_exp);
        chk(cause == cz_exp, cz_req, "cause code", {29'd0, cause}, {29'd0, cz_exp});
        epc_due = 0;
      end
      if (redirect || commit_en) begin
        if (sb.size() == 0) begin
          chk(0, "R8", "unexpected commit/redirect at done_pc", done_pc, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(redirect == it.is_exc, it.req, "event kind (1=exception)",
              {31'd0, redirect}, {31'd0, it.is_exc});
          chk(done_pc == it.pc, it.req, "pc at end of memory", done_pc, it.pc);
          chk(cyc == it.due, "R3", "event cycle", cyc, it.due);
          if (redirect) begin
            chk(flush && redirect_pc == VEC, "R10", "flush/vector", redirect_pc, VEC);
            epc_due = 1; epc_exp = it.pc; cz_exp = it.cz; cz_req = it.req;
          end
        end
      end else if (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        it = sb.pop_front();
        chk(0, it.req, "missing event for pc", '0, it.pc);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    if_valid = 0; if_pc = '0; irq_req = 0;
    if_fault = 0; id_fault = 0; ex_fault = 0; mem_fault = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!redirect && !flush && !commit_en, "R1", "control outputs in reset",
        {29'd0, redirect, flush, commit_en}, '0);
    chk(epc == '0, "R1", "epc in reset", epc, '0);
    chk(cause == 3'd0, "R1", "cause in reset", {29'd0, cause}, '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    live  = 1;

    // R2: clean back-to-back flow
    for (int i = 0; i < 4; i++) begin
      exp_commit(32'h100 + 4*i, "R2");
      go(1, 32'h100 + 4*i, 0, 0, 0, 0, 0);
    end
    idle(4);

    // R3/R8/R10: fetch fault on B; C, D, E squashed; vector fetch flows
    exp_commit(32'h200, "R2");       go(1, 32'h200, 0, 0, 0, 0, 0);
    exp_exc(32'h204, 3'd2, "R5");    go(1, 32'h204, 1, 0, 0, 0, 0);
    go(1, 32'h208, 0, 0, 0, 0, 0);
    go(1, 32'h20C, 0, 0, 0, 0, 0);
    go(1, 32'h210, 0, 0, 0, 0, 0);   // in fetch during redirect: squashed
    exp_commit(VEC, "R10");          go(1, VEC, 0, 0, 0, 0, 0);
    idle(4);

    // R5: illegal opcode raised in decode
    exp_exc(32'h300, 3'd3, "R5");    go(1, 32'h300, 0, 0, 0, 0, 0);
    go(0, '0, 0, 0, 1, 0, 0);
    idle(4);

    // R5: overflow raised in execute
    exp_exc(32'h310, 3'd4, "R5");    go(1, 32'h310, 0, 0, 0, 0, 0);
    idle(1);
    go(0, '0, 0, 0, 0, 1, 0);
    idle(4);

    // R5: data address fault raised in memory
    exp_exc(32'h320, 3'd5, "R5");    go(1, 32'h320, 0, 0, 0, 0, 0);
    idle(2);
    go(0, '0, 0, 0, 0, 0, 1);
    idle(4);

    // R6: flagged at fetch, later flags ignored; first cause kept
    exp_exc(32'h330, 3'd2, "R6");    go(1, 32'h330, 1, 0, 0, 0, 0);
    go(0, '0, 0, 0, 1, 0, 0);
    go(0, '0, 0, 0, 0, 1, 0);
    go(0, '0, 0, 0, 0, 0, 1);
    idle(4);

    // R7: older A overflows after younger B was flagged at fetch
    exp_exc(32'h340, 3'd4, "R7");    go(1, 32'h340, 0, 0, 0, 0, 0);
    go(1, 32'h344, 1, 0, 0, 0, 0);
    go(0, '0, 0, 0, 1, 1, 0);
    idle(5);

    // R9: interrupt beats a fetch fault; also with no valid fetch
    exp_exc(32'h350, 3'd1, "R9");    go(1, 32'h350, 1, 1, 0, 0, 0);
    idle(4);
    exp_exc(32'h360, 3'd1, "R9");    go(0, 32'h360, 0, 1, 0, 0, 0);
    idle(4);

    // R11: faults on an empty pipeline have no effect
    for (int i = 0; i < 4; i++) go(0, 32'h370, 1, 0, 1, 1, 1);
    idle(4);
    chk(epc == 32'h360, "R11", "epc after faults on empty stages", epc, 32'h360);
    chk(cause == 3'd1, "R11", "cause after faults on empty stages", {29'd0, cause}, 32'd1);

    // R4: epc holds through clean traffic
    for (int i = 0; i < 3; i++) begin
      exp_commit(32'h500 + 4*i, "R2");
      go(1, 32'h500 + 4*i, 0, 0, 0, 0, 0);
    end
    idle(5);
    chk(epc == 32'h360, "R4", "epc held over commits", epc, 32'h360);
    chk(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule